// File: doc/BRIEF.md
# APB Register Bank with Per-Field Access Policies

This block is a small APB completer that holds four 32-bit registers on a word-aligned map. Each register is built from fields, and each field follows one access policy. A field may be a constant, a live view of an input, a stored value that is written and read back, a stored value that is written but never read back, a one-cycle command pulse, a sticky event bit that hardware sets and software clears by writing a one, or a pass-through whose value and strobes go straight to the surrounding logic. The bank decodes reads and writes and selects read data through a combinational mux. It never inserts wait states and never signals an error.

The neighbouring logic uses the per-field outputs, inputs and strobes directly. Two registered group strobes tell it that software has just updated a set of registers. Group 0 covers the control and data registers, and group 1 covers the status register. Each group strobe pulses in the cycle after the write that triggers it.

Top module: `apb_field_regbank`

## Requirements
- R1: `pready` is always 1 and `pslverr` is always 0. A write takes effect only in a cycle where `psel`, `penable` and `pwrite` are all 1, so a setup phase that has no access phase changes nothing.
- R2: Only address bits [3:2] select a register: 0 selects CTRL, 1 selects STATUS, 2 selects DATA and 3 selects ID. All other address bits are ignored, so for example 0x1C reads ID and 0xF03 reads CTRL.
- R3: Read data is a combinational function of the address and the current state. Bits that belong to no field read as 0: CTRL[15:9] and STATUS[31:18].
- R4: CTRL[7:0] is a read-write field with reset value 0x5A. A write to CTRL loads it at the clock edge that ends the access phase. It drives `ctrl_mode_o` and reads back its stored value, and it stays stable whenever CTRL is not written.
- R5: CTRL[31:16] is a write-only field with reset value 0. A write stores the value on `ctrl_cfg_o`, but a read always returns the reset value 0.
- R6: CTRL[8] is a self-clearing command. `ctrl_kick_o` equals `pwdata[8]` during the access phase of a CTRL write and is 0 at all other times. The bit reads back as 0.
- R7: STATUS[15:0] reads the current value of `stat_live_i`.
- R8: STATUS[16] and STATUS[17] are sticky event bits with reset value 0, shown on `stat_err0_o` and `stat_err1_o`. A set input that is high at a clock edge sets its bit. Writing 1 to the bit clears it, and writing 0 leaves it unchanged. When a set and a clear fall on the same edge, the set wins. Each bit reads back its state.
- R9: DATA is a 32-bit pass-through field. During the access phase of a DATA write, `data_wr_o` equals `pwdata` and `data_wen_o` is 1. During the access phase of a DATA read, `data_ren_o` is 1 and the read returns `data_rd_i`. Both strobes are 0 at all other times.
- R10: ID reads the constant 0x1234ABCD, and writes to it have no effect.
- R11: `grp_wstb_o[0]` is 1 for exactly the cycle after the access phase of a write to CTRL or DATA. `grp_wstb_o[1]` does the same for a write to STATUS. A write to ID raises neither bit.
- R12: A low `rst_n` resets all state at once, without waiting for a clock edge: `ctrl_mode_o`=0x5A, `ctrl_cfg_o`=0, both sticky bits 0 and `grp_wstb_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| ctrl_mode_o | output | 8 | Stored CTRL[7:0] |
| ctrl_kick_o | output | 1 | Command pulse from CTRL[8] |
| ctrl_cfg_o | output | 16 | Stored CTRL[31:16] |
| stat_live_i | input | 16 | Live value shown in STATUS[15:0] |
| stat_err0_set_i | input | 1 | Set request for STATUS[16] |
| stat_err1_set_i | input | 1 | Set request for STATUS[17] |
| stat_err0_o | output | 1 | State of STATUS[16] |
| stat_err1_o | output | 1 | State of STATUS[17] |
| data_wr_o | output | 32 | DATA write value (pass-through) |
| data_wen_o | output | 1 | DATA write strobe |
| data_ren_o | output | 1 | DATA read strobe |
| data_rd_i | input | 32 | Value returned on a DATA read |
| grp_wstb_o | output | 2 | Registered group write strobes |

## Verification
The assertions assume that the APB signals follow the protocol order: a setup cycle comes first, then one access cycle, with address, direction and write data held steady across both. They also assume that the set inputs and the pass-through read value are synchronous to `clk`. The stimulus meets these assumptions because every transfer comes from tasks that change inputs only at falling clock edges and keep `psel` high through both phases. The one deliberate exception is a setup phase with no access phase, which is used to show that nothing gets written.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

   typedef enum logic [3:0] {
      POL_RO,     // constant
      POL_ROV,    // live input
      POL_WO,     // stored, reads constant
      POL_RW,     // stored, reads stored
      POL_PW,     // pass-through write with strobe
      POL_PR,     // pass-through read with strobe
      POL_PRW,    // pass-through both ways
      POL_SC,     // self-clearing pulse
      POL_W1C     // sticky, write one to clear
   } field_pol_e;

   localparam int unsigned BUS_W      = 32;
   localparam int unsigned NUM_REGS   = 4;
   localparam int unsigned NUM_GROUPS = 2;

   localparam int unsigned REG_CTRL   = 0;
   localparam int unsigned REG_STATUS = 1;
   localparam int unsigned REG_DATA   = 2;
   localparam int unsigned REG_ID     = 3;

   localparam int unsigned MODE_LSB = 0;
   localparam int unsigned MODE_W   = 8;
   localparam int unsigned KICK_BIT = 8;
   localparam int unsigned CFG_LSB  = 16;
   localparam int unsigned CFG_W    = 16;
   localparam int unsigned LIVE_LSB = 0;
   localparam int unsigned LIVE_W   = 16;
   localparam int unsigned ERR_LSB  = 16;
   localparam int unsigned NUM_ERR  = 2;

   // group g membership is bits [g*NUM_REGS +: NUM_REGS], bit r = register r
   localparam logic [NUM_GROUPS*NUM_REGS-1:0] GROUP_MEMBERS = {
      4'b0010,   // group 1: STATUS
      4'b0101    // group 0: CTRL, DATA
   };

endpackage

// File: rtl/rb_apb_decode.sv
module rb_apb_decode #(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned BUS_W    = 32,
   localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int unsigned SLOT_LSB = $clog2(BUS_W / 8)
) (
   input  logic                psel,
   input  logic                penable,
   input  logic                pwrite,
   input  logic [ADDR_W-1:0]   paddr,
   output logic [NUM_REGS-1:0] wr_hit,
   output logic [NUM_REGS-1:0] rd_hit,
   output logic [IDX_W-1:0]    rd_idx,
   output logic                rd_ok
);

   if (ADDR_W < SLOT_LSB + IDX_W) begin : g_bad_addr
      $error("rb_apb_decode: ADDR_W too narrow for the register count");
   end

   logic wr_en;
   logic rd_en;
   logic [IDX_W-1:0] slot;
   logic unused_addr;

   assign wr_en  = psel & penable & pwrite;
   assign rd_en  = psel & penable & ~pwrite;
   assign slot   = paddr[SLOT_LSB +: IDX_W];
   assign rd_idx = slot;
   assign unused_addr = ^paddr;

   if ((1 << IDX_W) == NUM_REGS) begin : g_full_map
      assign rd_ok = 1'b1;
   end else begin : g_part_map
      assign rd_ok = ({1'b0, slot} < (IDX_W + 1)'(NUM_REGS));
   end

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
      assign wr_hit[r] = wr_en & (slot == IDX_W'(r));
      assign rd_hit[r] = rd_en & (slot == IDX_W'(r));
   end

endmodule

// File: rtl/rb_field.sv
module rb_field
   import regbank_pkg::*;
#(
   parameter field_pol_e  POLICY = POL_RW,
   parameter int unsigned W      = 1,
   parameter logic [W-1:0] RST   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_hit,
   input  logic         rd_hit,
   input  logic [W-1:0] wslice,
   input  logic [W-1:0] hw_in,
   output logic [W-1:0] q,
   output logic [W-1:0] rview,
   output logic         wstb,
   output logic         rstb
);

   if ((POLICY == POL_SC || POLICY == POL_W1C) && W != 1) begin : g_bad_width
      $error("rb_field: pulse and sticky policies need a one-bit field");
   end

   logic unused_in;
   assign unused_in = ^{clk, rst_n, wr_hit, rd_hit, wslice, hw_in};

   if (POLICY == POL_RW || POLICY == POL_WO) begin : g_store
      logic [W-1:0] store;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      store <= RST;
         else if (wr_hit) store <= wslice;
      end
      assign q     = store;
      assign rview = (POLICY == POL_RW) ? store : RST;
      assign wstb  = 1'b0;
      assign rstb  = 1'b0;
   end else if (POLICY == POL_W1C) begin : g_sticky
      logic [W-1:0] state;
      logic [W-1:0] clr;
      assign clr = wr_hit ? wslice : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) state <= RST;
         else        state <= (state & ~clr) | hw_in;
      end
      assign q     = state;
      assign rview = state;
      assign wstb  = 1'b0;
      assign rstb  = 1'b0;
   end else if (POLICY == POL_SC) begin : g_pulse
      assign q     = wslice & {W{wr_hit}};
      assign rview = RST;
      assign wstb  = 1'b0;
      assign rstb  = 1'b0;
   end else if (POLICY == POL_ROV) begin : g_live
      assign q     = '0;
      assign rview = hw_in;
      assign wstb  = 1'b0;
      assign rstb  = 1'b0;
   end else if (POLICY == POL_RO) begin : g_const
      assign q     = '0;
      assign rview = RST;
      assign wstb  = 1'b0;
      assign rstb  = 1'b0;
   end else begin : g_pass
      localparam bit PASS_W = (POLICY == POL_PW) || (POLICY == POL_PRW);
      localparam bit PASS_R = (POLICY == POL_PR) || (POLICY == POL_PRW);
      assign q     = PASS_W ? wslice : '0;
      assign wstb  = PASS_W & wr_hit;
      assign rstb  = PASS_R & rd_hit;
      assign rview = PASS_R ? hw_in : RST;
   end

endmodule

// File: rtl/rb_wstrobe_group.sv
module rb_wstrobe_group #(
   parameter int unsigned NUM_REGS   = 4,
   parameter int unsigned NUM_GROUPS = 2,
   parameter logic [NUM_GROUPS*NUM_REGS-1:0] MEMBERS = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_REGS-1:0]   wr_hit,
   output logic [NUM_GROUPS-1:0] wstb
);

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam logic [NUM_REGS-1:0] SEL = MEMBERS[g*NUM_REGS +: NUM_REGS];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) wstb[g] <= 1'b0;
         else        wstb[g] <= |(wr_hit & SEL);
      end
   end

endmodule

// File: rtl/apb_field_regbank.sv
module apb_field_regbank
   import regbank_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 12,
   parameter logic [MODE_W-1:0] MODE_RST = 8'h5A,
   parameter logic [CFG_W-1:0]  CFG_RST  = 16'h0000,
   parameter logic [BUS_W-1:0]  ID_VALUE = 32'h1234ABCD
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  psel,
   input  logic                  penable,
   input  logic                  pwrite,
   input  logic [ADDR_W-1:0]     paddr,
   input  logic [31:0]           pwdata,
   output logic [31:0]           prdata,
   output logic                  pready,
   output logic                  pslverr,
   output logic [7:0]            ctrl_mode_o,
   output logic                  ctrl_kick_o,
   output logic [15:0]           ctrl_cfg_o,
   input  logic [15:0]           stat_live_i,
   input  logic                  stat_err0_set_i,
   input  logic                  stat_err1_set_i,
   output logic                  stat_err0_o,
   output logic                  stat_err1_o,
   output logic [31:0]           data_wr_o,
   output logic                  data_wen_o,
   output logic                  data_ren_o,
   input  logic [31:0]           data_rd_i,
   output logic [1:0]            grp_wstb_o
);

   localparam int unsigned IDX_W = $clog2(NUM_REGS);

   if (BUS_W != 32) begin : g_bad_bus
      $error("apb_field_regbank: map is laid out for a 32-bit bus");
   end
   if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_addr
      $error("apb_field_regbank: ADDR_W must be 4 to 32");
   end

   logic [NUM_REGS-1:0] wr_hit;
   logic [NUM_REGS-1:0] rd_hit;
   logic [IDX_W-1:0]    rd_idx;
   logic                rd_ok;

   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   rb_apb_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS),
      .BUS_W    (BUS_W)
   ) i_decode (
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .wr_hit  (wr_hit),
      .rd_hit  (rd_hit),
      .rd_idx  (rd_idx),
      .rd_ok   (rd_ok)
   );

   // per-instance strobes that the policy leaves unused
   logic [6:0]        unused_wstb;
   logic [6:0]        unused_rstb;
   logic [LIVE_W-1:0] unused_live_q;
   logic [BUS_W-1:0]  unused_id_q;

   logic [MODE_W-1:0] mode_rv;
   logic              kick_rv;
   logic [CFG_W-1:0]  cfg_rv;
   logic [LIVE_W-1:0] live_rv;
   logic [NUM_ERR-1:0] err_set;
   logic [NUM_ERR-1:0] err_q;
   logic [NUM_ERR-1:0] err_rv;
   logic [BUS_W-1:0]  data_rv;
   logic [BUS_W-1:0]  id_rv;

   // ---------------- CTRL ----------------
   rb_field #(.POLICY(POL_RW), .W(MODE_W), .RST(MODE_RST)) i_mode (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_hit[REG_CTRL]), .rd_hit(rd_hit[REG_CTRL]),
      .wslice(pwdata[MODE_LSB +: MODE_W]), .hw_in('0),
      .q(ctrl_mode_o), .rview(mode_rv),
      .wstb(unused_wstb[0]), .rstb(unused_rstb[0])
   );

   rb_field #(.POLICY(POL_SC), .W(1), .RST(1'b0)) i_kick (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_hit[REG_CTRL]), .rd_hit(rd_hit[REG_CTRL]),
      .wslice(pwdata[KICK_BIT]), .hw_in(1'b0),
      .q(ctrl_kick_o), .rview(kick_rv),
      .wstb(unused_wstb[1]), .rstb(unused_rstb[1])
   );

   rb_field #(.POLICY(POL_WO), .W(CFG_W), .RST(CFG_RST)) i_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_hit[REG_CTRL]), .rd_hit(rd_hit[REG_CTRL]),
      .wslice(pwdata[CFG_LSB +: CFG_W]), .hw_in('0),
      .q(ctrl_cfg_o), .rview(cfg_rv),
      .wstb(unused_wstb[2]), .rstb(unused_rstb[2])
   );

   // ---------------- STATUS ----------------
   rb_field #(.POLICY(POL_ROV), .W(LIVE_W), .RST('0)) i_live (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_hit[REG_STATUS]), .rd_hit(rd_hit[REG_STATUS]),
      .wslice(pwdata[LIVE_LSB +: LIVE_W]), .hw_in(stat_live_i),
      .q(unused_live_q), .rview(live_rv),
      .wstb(unused_wstb[3]), .rstb(unused_rstb[3])
   );

   assign err_set = {stat_err1_set_i, stat_err0_set_i};

   for (genvar e = 0; e < NUM_ERR; e++) begin : g_err
      rb_field #(.POLICY(POL_W1C), .W(1), .RST(1'b0)) i_err (
         .clk(clk), .rst_n(rst_n),
         .wr_hit(wr_hit[REG_STATUS]), .rd_hit(rd_hit[REG_STATUS]),
         .wslice(pwdata[ERR_LSB + e]), .hw_in(err_set[e]),
         .q(err_q[e]), .rview(err_rv[e]),
         .wstb(unused_wstb[4 + e]), .rstb(unused_rstb[4 + e])
      );
   end

   assign stat_err0_o = err_q[0];
   assign stat_err1_o = err_q[1];

   // ---------------- DATA ----------------
   rb_field #(.POLICY(POL_PRW), .W(BUS_W), .RST('0)) i_data (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_hit[REG_DATA]), .rd_hit(rd_hit[REG_DATA]),
      .wslice(pwdata), .hw_in(data_rd_i),
      .q(data_wr_o), .rview(data_rv),
      .wstb(data_wen_o), .rstb(data_ren_o)
   );

   // ---------------- ID ----------------
   rb_field #(.POLICY(POL_RO), .W(BUS_W), .RST(ID_VALUE)) i_id (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_hit[REG_ID]), .rd_hit(rd_hit[REG_ID]),
      .wslice(pwdata), .hw_in('0),
      .q(unused_id_q), .rview(id_rv),
      .wstb(unused_wstb[6]), .rstb(unused_rstb[6])
   );

   // ---------------- read mux ----------------
   logic [BUS_W-1:0] reg_view [NUM_REGS];

   always_comb begin
      for (int r = 0; r < NUM_REGS; r++) reg_view[r] = '0;
      reg_view[REG_CTRL][MODE_LSB +: MODE_W]   = mode_rv;
      reg_view[REG_CTRL][KICK_BIT]             = kick_rv;
      reg_view[REG_CTRL][CFG_LSB +: CFG_W]     = cfg_rv;
      reg_view[REG_STATUS][LIVE_LSB +: LIVE_W] = live_rv;
      reg_view[REG_STATUS][ERR_LSB +: NUM_ERR] = err_rv;
      reg_view[REG_DATA]                       = data_rv;
      reg_view[REG_ID]                         = id_rv;
   end

   assign prdata = rd_ok ? reg_view[rd_idx] : '0;

   // ---------------- group strobes ----------------
   rb_wstrobe_group #(
      .NUM_REGS   (NUM_REGS),
      .NUM_GROUPS (NUM_GROUPS),
      .MEMBERS    (GROUP_MEMBERS)
   ) i_groups (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit),
      .wstb   (grp_wstb_o)
   );

endmodule

// File: rtl/rb_regbank_chk.sv
module rb_regbank_chk #(
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [31:0]       pwdata,
   input logic              pready,
   input logic              pslverr,
   input logic [7:0]        ctrl_mode_o,
   input logic              ctrl_kick_o,
   input logic              stat_err0_set_i,
   input logic              stat_err0_o,
   input logic              data_wen_o,
   input logic              data_ren_o,
   input logic [1:0]        grp_wstb_o
);

   logic wr_acc;
   logic rd_acc;
   assign wr_acc = psel && penable && pwrite;
   assign rd_acc = psel && penable && !pwrite;

   assert_handshake_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pready && !pslverr);

   assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_acc && paddr[3:2] == 2'd0) |=> $stable(ctrl_mode_o));

   assert_kick_only_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_kick_o |-> (wr_acc && paddr[3:2] == 2'd0 && pwdata[8]));

   assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_err0_set_i |=> stat_err0_o);

   assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_err0_o && !(wr_acc && paddr[3:2] == 2'd1 && pwdata[16])) |=> stat_err0_o);

   assert_sticky_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && paddr[3:2] == 2'd1 && pwdata[16] && !stat_err0_set_i) |=> !stat_err0_o);

   assert_data_wen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      data_wen_o |-> (wr_acc && paddr[3:2] == 2'd2));

   assert_data_ren_R9: assert property (@(posedge clk) disable iff (!rst_n)
      data_ren_o |-> (rd_acc && paddr[3:2] == 2'd2));

   assert_grp0_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && (paddr[3:2] == 2'd0 || paddr[3:2] == 2'd2)) |=> grp_wstb_o[0]);

   assert_grp1_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && paddr[3:2] == 2'd1) |=> grp_wstb_o[1]);

   assert_grp_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_acc && paddr[3:2] != 2'd3) |=> (grp_wstb_o == 2'b00));

endmodule

bind apb_field_regbank rb_regbank_chk #(.ADDR_W(ADDR_W)) i_rb_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .psel            (psel),
   .penable         (penable),
   .pwrite          (pwrite),
   .paddr           (paddr),
   .pwdata          (pwdata),
   .pready          (pready),
   .pslverr         (pslverr),
   .ctrl_mode_o     (ctrl_mode_o),
   .ctrl_kick_o     (ctrl_kick_o),
   .stat_err0_set_i (stat_err0_set_i),
   .stat_err0_o     (stat_err0_o),
   .data_wen_o      (data_wen_o),
   .data_ren_o      (data_ren_o),
   .grp_wstb_o      (grp_wstb_o)
);

// File: tb/test_apb_field_regbank.sv
`timescale 1ns/1ps
module test_apb_field_regbank;

   localparam int unsigned AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [31:0]   pwdata = '0;
   logic [31:0]   prdata;
   logic          pready, pslverr;
   logic [7:0]    ctrl_mode_o;
   logic          ctrl_kick_o;
   logic [15:0]   ctrl_cfg_o;
   logic [15:0]   stat_live_i = '0;
   logic          stat_err0_set_i = 1'b0, stat_err1_set_i = 1'b0;
   logic          stat_err0_o, stat_err1_o;
   logic [31:0]   data_wr_o;
   logic          data_wen_o, data_ren_o;
   logic [31:0]   data_rd_i = '0;
   logic [1:0]    grp_wstb_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   apb_field_regbank #(.ADDR_W(AW)) i_apb_field_regbank (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
      .ctrl_mode_o(ctrl_mode_o), .ctrl_kick_o(ctrl_kick_o), .ctrl_cfg_o(ctrl_cfg_o),
      .stat_live_i(stat_live_i), .stat_err0_set_i(stat_err0_set_i),
      .stat_err1_set_i(stat_err1_set_i), .stat_err0_o(stat_err0_o), .stat_err1_o(stat_err1_o),
      .data_wr_o(data_wr_o), .data_wen_o(data_wen_o), .data_ren_o(data_ren_o),
      .data_rd_i(data_rd_i), .grp_wstb_o(grp_wstb_o)
   );

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } exp_t;

   exp_t sb_q[$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // monitor: read data compared late in the access cycle
   always @(negedge clk) begin
      exp_t item;
      #2;
      if (psel && penable && !pwrite) begin
         if (sb_q.size() == 0) begin
            checks++;
            failures++;
            $display("FAIL R2 unexpected read actual=0x%08h expected=none", prdata);
         end else begin
            item = sb_q.pop_front();
            chk(item.tag, prdata, item.exp);
         end
      end
   end

   task automatic bus_setup(input logic wr, input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
   endtask

   task automatic bus_access();
      @(negedge clk);
      penable = 1'b1;
   endtask

   task automatic bus_idle();
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
      bus_setup(1'b1, a, d);
      bus_access();
      bus_idle();
   endtask

   task automatic bus_read(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
      exp_t it;
      it.exp = exp;
      it.tag = tag;
      sb_q.push_back(it);
      bus_setup(1'b0, a, 32'h0);
      bus_access();
      bus_idle();
   endtask

   initial begin
      // ---- reset state (R12, R1)
      repeat (3) @(negedge clk);
      chk("R12 mode reset", {24'h0, ctrl_mode_o}, 32'h5A);
      chk("R12 cfg reset", {16'h0, ctrl_cfg_o}, 32'h0);
      chk("R12 sticky reset", {30'h0, stat_err1_o, stat_err0_o}, 32'h0);
      chk("R12 group strobe reset", {30'h0, grp_wstb_o}, 32'h0);
      chk("R1 ready/err ties", {30'h0, pready, pslverr}, 32'h2);
      rst_n = 1'b1;

      // ---- plain reads (R7, R10, R4)
      stat_live_i = 16'hBEEF;
      data_rd_i = 32'hCAFEF00D;
      bus_read(12'h000, 32'h0000005A, "R4 CTRL read after reset");
      bus_read(12'h004, 32'h0000BEEF, "R7 STATUS live bits");
      bus_read(12'h00C, 32'h1234ABCD, "R10 ID constant");

      // ---- CTRL write: rw, sc, wo, gap bits (R4 R5 R6 R3 R11)
      bus_setup(1'b1, 12'h000, 32'hABCDFF33);
      bus_access();
      #1;
      chk("R6 kick pulse during access", {31'h0, ctrl_kick_o}, 32'h1);
      chk("R9 no data strobe on CTRL write", {31'h0, data_wen_o}, 32'h0);
      bus_idle();
      #1;
      chk("R4 mode loaded", {24'h0, ctrl_mode_o}, 32'h33);
      chk("R5 cfg stored", {16'h0, ctrl_cfg_o}, 32'hABCD);
      chk("R6 kick cleared", {31'h0, ctrl_kick_o}, 32'h0);
      chk("R11 group0 pulse after CTRL write", {30'h0, grp_wstb_o}, 32'h1);
      @(negedge clk); #1;
      chk("R11 group strobe lasts one cycle", {30'h0, grp_wstb_o}, 32'h0);
      bus_read(12'h000, 32'h00000033, "R3 R5 R6 CTRL readback with gaps zero");

      // ---- setup phase without access writes nothing (R1)
      bus_setup(1'b1, 12'h000, 32'h00000077);
      bus_idle();
      #1;
      chk("R1 setup-only leaves mode", {24'h0, ctrl_mode_o}, 32'h33);

      // ---- address aliasing (R2)
      bus_read(12'h01C, 32'h1234ABCD, "R2 alias 0x1C to ID");
      bus_read(12'hF03, 32'h00000033, "R2 alias 0xF03 to CTRL");

      // ---- sticky bits (R8)
      @(negedge clk); stat_err0_set_i = 1'b1;
      @(negedge clk); stat_err0_set_i = 1'b0; #1;
      chk("R8 hardware set", {30'h0, stat_err1_o, stat_err0_o}, 32'h1);
      bus_read(12'h004, 32'h0001BEEF, "R8 R3 STATUS readback sticky set");
      bus_write(12'h004, 32'hFFFCFFFF);
      #1;
      chk("R8 writing zero keeps bit", {31'h0, stat_err0_o}, 32'h1);
      chk("R11 group1 pulse after STATUS write", {30'h0, grp_wstb_o}, 32'h2);
      bus_setup(1'b1, 12'h004, 32'h00010000);
      bus_access();
      stat_err0_set_i = 1'b1;
      bus_idle();
      stat_err0_set_i = 1'b0;
      #1;
      chk("R8 set wins over clear", {31'h0, stat_err0_o}, 32'h1);
      @(negedge clk); stat_err1_set_i = 1'b1;
      @(negedge clk); stat_err1_set_i = 1'b0;
      bus_write(12'h004, 32'h00010000);
      #1;
      chk("R8 write one clears only its bit", {30'h0, stat_err1_o, stat_err0_o}, 32'h2);
      bus_write(12'h004, 32'h00020000);
      #1;
      chk("R8 second bit cleared", {30'h0, stat_err1_o, stat_err0_o}, 32'h0);

      // ---- DATA pass-through (R9)
      bus_setup(1'b1, 12'h008, 32'h600DD00D);
      bus_access();
      #1;
      chk("R9 data write value", data_wr_o, 32'h600DD00D);
      chk("R9 data write strobe", {31'h0, data_wen_o}, 32'h1);
      chk("R9 no read strobe on write", {31'h0, data_ren_o}, 32'h0);
      bus_idle();
      #1;
      chk("R9 write strobe gone", {31'h0, data_wen_o}, 32'h0);
      chk("R11 group0 pulse after DATA write", {30'h0, grp_wstb_o}, 32'h1);
      sb_q.push_back('{32'hCAFEF00D, "R9 DATA read returns input"});
      bus_setup(1'b0, 12'h008, 32'h0);
      bus_access();
      #1;
      chk("R9 data read strobe", {31'h0, data_ren_o}, 32'h1);
      chk("R9 no write strobe on read", {31'h0, data_wen_o}, 32'h0);
      bus_idle();

      // ---- ID write ignored (R10, R11)
      bus_write(12'h00C, 32'hFFFFFFFF);
      #1;
      chk("R11 ID write raises no group", {30'h0, grp_wstb_o}, 32'h0);
      bus_read(12'h00C, 32'h1234ABCD, "R10 ID unchanged after write");

      // ---- asynchronous reset (R12)
      @(negedge clk); stat_err1_set_i = 1'b1;
      @(negedge clk); stat_err1_set_i = 1'b0;
      #1;
      rst_n = 1'b0;
      #0.5;
      chk("R12 async mode", {24'h0, ctrl_mode_o}, 32'h5A);
      chk("R12 async cfg", {16'h0, ctrl_cfg_o}, 32'h0);
      chk("R12 async sticky", {31'h0, stat_err1_o}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);

      chk("R2 scoreboard drained", sb_q.size(), 32'h0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL R12 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule